// File: doc/BRIEF.md
# Sector Write-Protect Gate

This block decides whether each program or erase request may proceed. Every request names a target sector and a page. The block combines three sources into one verdict: a write-protect pin with a noise filter, a software protection flag that enable and disable commands control, and a per-sector lock map that arrives as a flat vector from storage outside the block. Protection is in force while the filtered pin is asserted, or while the software flag is set. A request is refused only when protection is in force and the map marks the target region as locked.

The software flag remembers what happened while the pin was asserted. An enable command issued before or during a pin-asserted interval stays in force after the pin is released. A disable command clears the flag only while the filtered pin is released. While the pin is asserted, the lock map is reported as read-only. Sector 0 is divided into a small low region and a larger high region, and each region has its own lock field.

The verdict appears one cycle after the request as either a write strobe or a reject pulse. Map storage and serial command decoding belong to neighbouring blocks.

Top module: `sect_wp_gate`

## Requirements
- R1: After reset, prot_on is 0, map_wr_en is 1, and neither wr_go nor wr_reject is high.
- R2: The pin passes through a two-stage synchroniser and then a filter that needs FILT_LEN (default 16) consecutive samples that differ from the filtered level before that level changes. A low pulse shorter than FILT_LEN cycles leaves map_wr_en and prot_on unchanged, and a level held for FILT_LEN+3 cycles is taken up.
- R3: While the filtered pin is asserted (wp_n_raw low), prot_on is 1 and map_wr_en is 0. While it is released, map_wr_en is 1.
- R4: A disable command (dis_cmd high for one cycle) while the filtered pin is asserted is ignored: the software flag keeps its value.
- R5: An enable command issued while the pin is released sets protection. Protection stays set through a later pin assertion and release.
- R6: An enable followed by a disable, both while the pin is released, leaves only the pin in control. After a later assertion and release, prot_on returns to 0.
- R7: An enable issued while the filtered pin is asserted keeps prot_on at 1 after release, until a disable arrives with the pin released.
- R8: If enable and disable are high in the same cycle, enable wins and the flag is set.
- R9: For sectors 1 to NSECT-1, a map byte of FFh means locked. Any other value, 00h included, means unlocked. The byte for sector s is map_bits[8s+7:8s].
- R10: Sector 0 is split by page. Pages below SUB0_PAGES (default 8) are locked when map byte bits 7:6 are 11. Higher pages are locked when bits 5:4 are 11. Bits 3:0 have no effect.
- R11: Exactly one cycle after a cycle with req_valid high, exactly one of wr_go and wr_reject pulses high. Neither pulses without a request.
- R12: While prot_on is 0, every request yields wr_go, whatever the map holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_n_raw | input | 1 | Raw write-protect pin, active low |
| en_cmd | input | 1 | One-cycle enable-protection command strobe |
| dis_cmd | input | 1 | One-cycle disable-protection command strobe |
| req_valid | input | 1 | Program or erase request strobe |
| req_sector | input | SEC_W (6) | Target sector number |
| req_page | input | PAGE_W (7) | Page number within the target sector |
| map_bits | input | NSECT*8 (512) | Lock map, one byte per sector, sector s at bits 8s+7:8s |
| wr_go | output | 1 | Write strobe, one cycle after an allowed request |
| wr_reject | output | 1 | Reject pulse, one cycle after a refused request |
| prot_on | output | 1 | Effective protection in force |
| map_wr_en | output | 1 | Lock map writable (1) or read-only (0) |

## Verification
The assertions assume that command strobes and requests appear only after the internal reset has released. They also assume that map_bits and the request fields are stable in any cycle where req_valid is high, because the verdict samples them at that edge. The bench drives every input on the falling edge and keeps the map constant around each request. It waits more than the filter window after each pin change before it issues commands whose effect depends on the filtered level. The disable-ignored property compares the software flag over one cycle. The bench therefore issues disable only with the pin settled, so that the filtered level cannot change in the same cycle.

// File: rtl/sect_wp_pkg.sv
package sect_wp_pkg;
  localparam int unsigned MAP_W     = 8;
  localparam logic [1:0]  FIELD_ON  = 2'b11;

  typedef struct packed {
    logic go;
    logic rej;
  } verdict_t;
endpackage

// File: rtl/wp_noise_filter.sv
module wp_noise_filter #(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_raw,
  output logic wp_act
);
  localparam int unsigned CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [1:0]       sync_q;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pin_n_raw};
  end

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (sync_q[1] != lvl_q) begin
      if (cnt_q == CNT_LAST) begin
        lvl_d = sync_q[1];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign wp_act = ~lvl_q;
endmodule

// File: rtl/prot_flag.sv
module prot_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_act,
  input  logic en_cmd,
  input  logic dis_cmd,
  output logic sw_en
);
  logic flag_q, flag_d, flag_ce;

  always_comb begin
    flag_ce = en_cmd | (dis_cmd & ~wp_act);
    flag_d  = en_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign sw_en = flag_q;
endmodule

// File: rtl/map_lookup.sv
module map_lookup
  import sect_wp_pkg::*;
#(
  parameter int unsigned NSECT      = 64,
  parameter int unsigned PAGE_W     = 7,
  parameter int unsigned SUB0_PAGES = 8,
  localparam int unsigned SEC_W     = $clog2(NSECT)
) (
  input  logic [NSECT*MAP_W-1:0] map_bits,
  input  logic [SEC_W-1:0]       sector,
  input  logic [PAGE_W-1:0]      page,
  output logic                   locked
);
  logic [NSECT-1:0] lock_vec;
  logic             low_region;

  assign low_region = (page < PAGE_W'(SUB0_PAGES));

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    logic [MAP_W-1:0] byte_s;
    assign byte_s = map_bits[s*MAP_W +: MAP_W];
    if (s == 0) begin : g_split
      assign lock_vec[s] = low_region ? (byte_s[7:6] == FIELD_ON)
                                      : (byte_s[5:4] == FIELD_ON);
    end else begin : g_whole
      assign lock_vec[s] = &byte_s;
    end
  end

  assign locked = lock_vec[sector];
endmodule

// File: rtl/req_judge.sv
module req_judge
  import sect_wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic prot_on,
  input  logic locked,
  output logic wr_go,
  output logic wr_reject
);
  verdict_t v_q, v_d;

  always_comb begin
    v_d.rej = req_valid & prot_on & locked;
    v_d.go  = req_valid & ~v_d.rej;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  assign wr_go     = v_q.go;
  assign wr_reject = v_q.rej;
endmodule

// File: rtl/sect_wp_gate.sv
module sect_wp_gate
  import sect_wp_pkg::*;
#(
  parameter int unsigned NSECT      = 64,
  parameter int unsigned PAGE_W     = 7,
  parameter int unsigned SUB0_PAGES = 8,
  parameter int unsigned FILT_LEN   = 16,
  localparam int unsigned SEC_W     = $clog2(NSECT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wp_n_raw,
  input  logic                   en_cmd,
  input  logic                   dis_cmd,
  input  logic                   req_valid,
  input  logic [SEC_W-1:0]       req_sector,
  input  logic [PAGE_W-1:0]      req_page,
  input  logic [NSECT*MAP_W-1:0] map_bits,
  output logic                   wr_go,
  output logic                   wr_reject,
  output logic                   prot_on,
  output logic                   map_wr_en
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       wp_act;
  logic       sw_en_q;
  logic       locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wp_noise_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n_s), .pin_n_raw(wp_n_raw), .wp_act(wp_act)
  );

  prot_flag u_flag (
    .clk(clk), .rst_n(rst_n_s), .wp_act(wp_act),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .sw_en(sw_en_q)
  );

  map_lookup #(.NSECT(NSECT), .PAGE_W(PAGE_W), .SUB0_PAGES(SUB0_PAGES)) u_map (
    .map_bits(map_bits), .sector(req_sector), .page(req_page), .locked(locked)
  );

  assign prot_on   = wp_act | sw_en_q;
  assign map_wr_en = ~wp_act;

  req_judge u_judge (
    .clk(clk), .rst_n(rst_n_s), .req_valid(req_valid), .prot_on(prot_on),
    .locked(locked), .wr_go(wr_go), .wr_reject(wr_reject)
  );
endmodule

module sect_wp_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic en_cmd,
  input logic dis_cmd,
  input logic req_valid,
  input logic wr_go,
  input logic wr_reject,
  input logic prot_on,
  input logic map_wr_en,
  input logic sw_en
);
  a_r11_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_go, wr_reject}));
  a_r11_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (wr_go || wr_reject));
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(wr_go || wr_reject));
  a_r3_readonly_implies_prot: assert property (@(posedge clk) disable iff (!rst_n)
    !map_wr_en |-> prot_on);
  a_r4_dis_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_cmd && !map_wr_en && sw_en) |=> sw_en);
  a_r8_enable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    en_cmd |=> (sw_en && prot_on));
  a_r12_open_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_on) |=> wr_go);
endmodule

bind sect_wp_gate sect_wp_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
  .req_valid(req_valid), .wr_go(wr_go), .wr_reject(wr_reject),
  .prot_on(prot_on), .map_wr_en(map_wr_en), .sw_en(sw_en_q)
);

// File: tb/sect_wp_gate_tb.sv
module sect_wp_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 64;
  localparam int SETTLE = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n_raw = 1'b1;
  logic en_cmd = 1'b0, dis_cmd = 1'b0, req_valid = 1'b0;
  logic [5:0] req_sector = '0;
  logic [6:0] req_page = '0;
  logic [NS*8-1:0] map_bits;
  logic [7:0] mb [NS];
  logic wr_go, wr_reject, prot_on, map_wr_en;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int s = 0; s < NS; s++) map_bits[s*8 +: 8] = mb[s];

  sect_wp_gate u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n_raw(wp_n_raw), .en_cmd(en_cmd),
    .dis_cmd(dis_cmd), .req_valid(req_valid), .req_sector(req_sector),
    .req_page(req_page), .map_bits(map_bits), .wr_go(wr_go),
    .wr_reject(wr_reject), .prot_on(prot_on), .map_wr_en(map_wr_en)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_lock(logic [7:0] b, int s, int p);
    if (s == 0) return (p < 8) ? (b[7:6] == 2'b11) : (b[5:4] == 2'b11);
    return b == 8'hFF;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit e, bit d);
    @(negedge clk); en_cmd = e; dis_cmd = d;
    @(negedge clk); en_cmd = 1'b0; dis_cmd = 1'b0;
  endtask

  task automatic set_pin(bit v);
    @(negedge clk); wp_n_raw = v;
    wait_cyc(SETTLE);
  endtask

  task automatic do_req(int s, int p, bit exp_rej, string req);
    @(negedge clk); req_valid = 1'b1; req_sector = 6'(s); req_page = 7'(p);
    @(negedge clk); req_valid = 1'b0;
    chk(wr_go == !exp_rej && wr_reject == exp_rej, req,
        {wr_go, wr_reject}, {!exp_rej, exp_rej});
  endtask

  task automatic sweep(bit prot, string req);
    int pages [6] = '{0, 3, 7, 8, 9, 127};
    for (int s = 1; s < NS; s++) begin
      case (s % 3)
        0: mb[s] = 8'hFF;
        1: mb[s] = 8'h00;
        default: mb[s] = 8'(s * 3) & 8'hF7;
      endcase
    end
    for (int n = 0; n < 16; n++) begin
      mb[0] = {4'(n), 4'(n * 7)};
      for (int k = 0; k < 6; k++)
        do_req(0, pages[k], prot && exp_lock(mb[0], 0, pages[k]), "R10");
    end
    for (int s = 1; s < NS; s++)
      do_req(s, s % 128, prot && exp_lock(mb[s], s, 0), req);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) mb[s] = 8'hFF;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    // R1 reset state
    chk(prot_on == 0, "R1", prot_on, 0);
    chk(map_wr_en == 1, "R1", map_wr_en, 1);
    chk(!wr_go && !wr_reject, "R1", {wr_go, wr_reject}, 0);

    // R12 protection off, map fully locked
    for (int s = 0; s < NS; s += 7) do_req(s, 0, 1'b0, "R12");
    sweep(1'b0, "R12");

    // R2 glitch shorter than filter
    @(negedge clk); wp_n_raw = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 9) wp_n_raw = 1'b1;
    end
    begin
      bit held = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!map_wr_en || prot_on) held = 1'b0;
      end
      chk(held, "R2", held, 1);
    end

    // R2/R3 held assertion taken up
    @(negedge clk); wp_n_raw = 1'b0;
    wait_cyc(12);
    chk(map_wr_en == 1, "R2", map_wr_en, 1);
    wait_cyc(12);
    chk(map_wr_en == 0, "R3", map_wr_en, 0);
    chk(prot_on == 1, "R3", prot_on, 1);

    // R9/R10 decode with pin-driven protection
    sweep(1'b1, "R9");

    // R4 disable ignored while asserted (flag clear): no effect on release
    pulse(1'b0, 1'b1);
    chk(prot_on == 1, "R4", prot_on, 1);
    // R7 enable while asserted, R4 disable ignored with flag set
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    set_pin(1'b1);
    chk(map_wr_en == 1, "R3", map_wr_en, 1);
    chk(prot_on == 1, "R4", prot_on, 1);
    do_req(5, 0, exp_lock(mb[5], 5, 0), "R7");
    pulse(1'b0, 1'b1);
    chk(prot_on == 0, "R7", prot_on, 0);

    // R5 enable while high survives assertion and release
    pulse(1'b1, 1'b0);
    chk(prot_on == 1, "R5", prot_on, 1);
    set_pin(1'b0);
    set_pin(1'b1);
    chk(prot_on == 1, "R5", prot_on, 1);
    pulse(1'b0, 1'b1);
    chk(prot_on == 0, "R5", prot_on, 0);

    // R6 enable then disable while high, pin alone controls
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    set_pin(1'b0);
    chk(prot_on == 1, "R6", prot_on, 1);
    set_pin(1'b1);
    chk(prot_on == 0, "R6", prot_on, 0);
    do_req(3, 0, 1'b0, "R6");

    // R8 simultaneous strobes
    pulse(1'b1, 1'b1);
    chk(prot_on == 1, "R8", prot_on, 1);
    pulse(1'b0, 1'b1);
    chk(prot_on == 0, "R8", prot_on, 0);

    // R11 no verdict without request
    wait_cyc(2);
    chk(!wr_go && !wr_reject, "R11", {wr_go, wr_reject}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule